// File: doc/BRIEF.md
# Clock Distribution Channel Divider with Half-Cycle Coarse Delay

This block is one output lane of a clock distribution tree. It divides a fast input clock by a programmable integer from 1 to 256. It also moves the divided output's first edge later by a programmable count of half input-clock periods, from 0 to 31. The block is modelled with a double-rate enable: `clk` runs at twice the divider input rate, so one `clk` cycle is one half input period. One coarse delay step is therefore one `clk` cycle, and an input period of N cycles spans 2N `clk` cycles.

The lane is held static, with the output low and nothing toggling, whenever it is held. It is held while `sync_req` is high, and also from reset until calibration is reported done. New settings are staged with the `apply` strobe. They are copied into the active set only while the lane is held, so they first take effect when the hold is released. On every release, the lane counts exactly its programmed delay and then starts from a rising edge. Lanes with equal settings that are released together therefore produce edge-aligned outputs.

Top module: `chdiv_channel`

## Requirements
- R1: `div_code` value v selects ratio N = v+1, so N runs from 1 to 256. The output period is 2N `clk` cycles, which is N input periods.
- R2: For even N, `clk_out` is high for N `clk` cycles and low for N `clk` cycles, and each period starts with its high phase.
- R3: For odd N of 3 or more, `clk_out` is high for N+1 `clk` cycles and low for N-1. For N = 1 it is high for 1 cycle and low for 1 cycle.
- R4: Counting the first rising `clk` edge after the hold is released as edge 0, the first rising edge of `clk_out` is produced at edge D, where D = `dly_code` (0 to 31). Before that edge the output is low.
- R5: While `sync_req` is high, `clk_out` and `running` are low from the next `clk` edge onward and do not toggle.
- R6: After reset the lane stays held until `cal_done` is seen high at a `clk` edge. No output edge appears before that.
- R7: `apply` captures `div_code` and `dly_code` as the staged settings. The active settings are reloaded from the staged set only while the lane is held. An `apply` while running leaves the current waveform unchanged, and the new values take effect at the next release.
- R8: `running` rises together with the first rising edge of `clk_out` after a release. It stays high while the output toggles and drops when the lane is held.
- R9: The reset state (`rst` synchronous, active high) has `clk_out` = 0 and `running` = 0, with staged settings N = 1 and D = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one cycle is half an input period |
| rst | input | 1 | Synchronous reset, active high |
| cal_done | input | 1 | Calibration finished indication; releases the post-reset hold |
| sync_req | input | 1 | Holds the lane static while high |
| apply | input | 1 | Captures the divide and delay codes into the staged set |
| div_code | input | 8 | Divide ratio minus one |
| dly_code | input | 5 | Coarse delay in half input periods |
| clk_out | output | 1 | Divided, delayed clock (registered) |
| running | output | 1 | High while the output toggles |

## Verification
A bad delay counter shows up at the ports on the very first edge after a release, because the first rise lands one or more cycles away from edge D. A bad period counter or high-length value shows up within one output period, as a wrong high or low run, at the largest ratio after 512 cycles. A leak of staged settings into the active set shows up in the first period after an `apply` made while running. A missing hold shows up as an edge one cycle after `sync_req` rises, or before `cal_done`.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;
  typedef enum logic {
    SEQ_WAIT = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/chdiv_cfg.sv
module chdiv_cfg #(
  parameter int DIV_W = 8,
  parameter int DLY_W = 5,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             apply,
  input  logic [DIV_W-1:0] div_code,
  input  logic [DLY_W-1:0] dly_code,
  output logic [CNT_W-1:0] act_last,
  output logic [CNT_W-1:0] act_hi,
  output logic [DLY_W-1:0] act_dly
);
  logic [DIV_W-1:0] pend_div;
  logic [DLY_W-1:0] pend_dly;
  logic [DIV_W-1:0] sel_div;
  logic [DLY_W-1:0] sel_dly;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] hi_len;

  // a same-cycle apply wins over the staged value
  assign sel_div = apply ? div_code : pend_div;
  assign sel_dly = apply ? dly_code : pend_dly;
  assign ratio   = {1'b0, sel_div} + CNT_W'(1);

  always_comb begin
    if (sel_div == '0) hi_len = CNT_W'(1);
    else               hi_len = ratio + CNT_W'(ratio[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_div <= '0;
      pend_dly <= '0;
      act_last <= CNT_W'(1);
      act_hi   <= CNT_W'(1);
      act_dly  <= '0;
    end else begin
      if (apply) begin
        pend_div <= div_code;
        pend_dly <= dly_code;
      end
      if (hold) begin
        act_last <= {sel_div, 1'b1};
        act_hi   <= hi_len;
        act_dly  <= sel_dly;
      end
    end
  end

  // R7: active settings frozen while released
  a_r7_active_frozen: assert property (@(posedge clk) disable iff (rst)
    (!hold && $past(!hold)) |-> ($stable(act_last) && $stable(act_hi) && $stable(act_dly)));
endmodule

// File: rtl/chdiv_seq.sv
module chdiv_seq
  import chdiv_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 5,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [CNT_W-1:0] act_last,
  input  logic [CNT_W-1:0] act_hi,
  input  logic [DLY_W-1:0] act_dly,
  output logic             out_q,
  output logic             run_q
);
  seq_state_e       st;
  logic [CNT_W-1:0] pcnt;
  logic [CNT_W-1:0] pnext;
  logic [DLY_W-1:0] dcnt;

  assign pnext = (pcnt == act_last) ? '0 : pcnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st    <= SEQ_WAIT;
      out_q <= 1'b0;
      run_q <= 1'b0;
      pcnt  <= '0;
      dcnt  <= '0;
    end else begin
      case (st)
        SEQ_WAIT: begin
          if (dcnt == act_dly) begin
            st    <= SEQ_RUN;
            out_q <= 1'b1;
            run_q <= 1'b1;
            pcnt  <= '0;
          end else begin
            dcnt <= dcnt + DLY_W'(1);
          end
        end
        default: begin
          pcnt  <= pnext;
          out_q <= (pnext < act_hi);
        end
      endcase
    end
  end

  // R1: phase counter stays inside one period
  a_r1_phase_bound: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (pcnt <= act_last));
  // R2: a rising edge while running only at a period wrap
  a_r2_rise_at_wrap: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_q) && $past(run_q)) |-> ($past(pcnt) == act_last));
  // R8: no high output without the running flag
  a_r8_out_needs_run: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !out_q);
  // R4: delay counter never passes the programmed delay
  a_r4_delay_bound: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_WAIT) |-> (dcnt <= act_dly));
endmodule

// File: rtl/chdiv_channel.sv
module chdiv_channel #(
  parameter int DIV_W = 8,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_done,
  input  logic             sync_req,
  input  logic             apply,
  input  logic [DIV_W-1:0] div_code,
  input  logic [DLY_W-1:0] dly_code,
  output logic             clk_out,
  output logic             running
);
  localparam int CNT_W = DIV_W + 1;

  logic             cal_ok;
  logic             hold;
  logic [CNT_W-1:0] act_last;
  logic [CNT_W-1:0] act_hi;
  logic [DLY_W-1:0] act_dly;

  always_ff @(posedge clk) begin
    if (rst)           cal_ok <= 1'b0;
    else if (cal_done) cal_ok <= 1'b1;
  end

  assign hold = sync_req | ~cal_ok;

  chdiv_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst(rst), .hold(hold), .apply(apply),
    .div_code(div_code), .dly_code(dly_code),
    .act_last(act_last), .act_hi(act_hi), .act_dly(act_dly)
  );

  chdiv_seq #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .hold(hold),
    .act_last(act_last), .act_hi(act_hi), .act_dly(act_dly),
    .out_q(clk_out), .run_q(running)
  );

  // R5: sync request silences the lane on the next edge
  a_r5_sync_static: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> (!clk_out && !running));
  // R6: nothing toggles before calibration is reported
  a_r6_wait_cal: assert property (@(posedge clk) disable iff (rst)
    !cal_ok |-> (!clk_out && !running));
endmodule

// File: tb/chdiv_channel_bench.sv
module chdiv_channel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_done = 1'b0;
  logic       sync_req = 1'b0;
  logic       apply = 1'b0;
  logic [7:0] div_code = '0;
  logic [4:0] dly_code = '0;
  logic       clk_out;
  logic       running;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  chdiv_channel u_chdiv_channel (
    .clk(clk), .rst(rst), .cal_done(cal_done), .sync_req(sync_req),
    .apply(apply), .div_code(div_code), .dly_code(dly_code),
    .clk_out(clk_out), .running(running)
  );

  function automatic logic exp_out(int n, int d, int j);
    int k;
    int hi;
    if (j < d) return 1'b0;
    k  = (j - d) % (2 * n);
    hi = (n == 1) ? 1 : ((n % 2 == 1) ? n + 1 : n);
    return (k < hi);
  endfunction

  task automatic check2(string tag, logic o, logic r, logic eo, logic er);
    checks++;
    if (o !== eo || r !== er) begin
      fails++;
      $display("FAIL %s: clk_out/running = %b/%b, expected %b/%b", tag, o, r, eo, er);
    end
  endtask

  // caller is at a negedge just before edge j0 of a released run
  task automatic follow(string tag, int n, int d, int j0, int cnt);
    for (int j = j0; j < j0 + cnt; j++) begin
      @(posedge clk);
      @(negedge clk);
      apply = 1'b0;
      check2(tag, clk_out, running, exp_out(n, d, j), (j >= d));
    end
  endtask

  // hold, stage new codes, release; returns at negedge before edge 0
  task automatic hold_apply(string tag, int n, int d);
    sync_req = 1'b1;
    @(negedge clk);
    div_code = 8'(n - 1);
    dly_code = 5'(d);
    apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check2(tag, clk_out, running, 1'b0, 1'b0);
    end
    sync_req = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check2("R9 reset state", clk_out, running, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_no_cal;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check2("R6 held before cal_done", clk_out, running, 1'b0, 1'b0);
    end
  endtask

  task automatic t_cal_defaults;
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    follow("R9 default N=1 D=0 / R3", 1, 0, 0, 40);
  endtask

  task automatic t_even;
    hold_apply("R5 hold static", 4, 5);
    follow("R2 even N=4 D=5 / R4", 4, 5, 0, 60);
  endtask

  task automatic t_odd;
    hold_apply("R5 hold static", 5, 31);
    follow("R3 odd N=5 D=31 / R4", 5, 31, 0, 90);
    hold_apply("R5 hold static", 1, 3);
    follow("R3 N=1 D=3 / R8", 1, 3, 0, 30);
  endtask

  task automatic t_max;
    hold_apply("R5 hold static", 256, 7);
    follow("R1 N=256 D=7", 256, 7, 0, 1100);
  endtask

  task automatic t_apply_running;
    hold_apply("R5 hold static", 3, 2);
    follow("R3 odd N=3 D=2", 3, 2, 0, 20);
    div_code = 8'd1;
    dly_code = 5'd0;
    apply = 1'b1;
    follow("R7 apply while running ignored", 3, 2, 20, 40);
    sync_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check2("R5 sync mid-run static", clk_out, running, 1'b0, 1'b0);
    end
    sync_req = 1'b0;
    follow("R7 staged N=2 D=0 after release", 2, 0, 0, 30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_cal();
    t_cal_defaults();
    t_even();
    t_odd();
    t_max();
    t_apply_running();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule